// File: doc/BRIEF.md
# Parallel Host Register File for an Eight-Digit Character Display

This block is the host-side store of an eight-digit dot-matrix character display. A host writes to it over an asynchronous parallel bus made of an active-low chip enable, an active-low write strobe, an active-low flash-select line, a 4-bit address and an 8-bit data byte. The block brings the strobe into the system clock domain and acts on its rising edge. It steers each write to one of three stores: a character memory of eight 8-bit entries (a 7-bit character code plus a font page bit), an 8-entry flash-attribute bit memory, and a single 8-bit control word.

The scan and attribute logic downstream reads all three stores through flat read buses. Reset puts the stores into a known blank state. Setting the clear bit in the control word starts a timed clear. The clear fills the character memory with the space code, zeros the flash bits and marks the block busy for a parameterised number of clock cycles. While the block is busy, character and flash writes are dropped. A control word written with the clear bit low ends the busy period early.

Top module: `dispHostRegs`

## Requirements
- R1: After reset, every character entry reads 8'h20, every flash bit reads 0, the control word reads 8'h00 and clearBusy is low.
- R2: A strobe pulse made while hostCeN is high changes no store.
- R3: With hostFlN high and hostAddr[3]=1, the full data byte is stored in the character entry chosen by hostAddr[2:0]. Entry d appears on charFlat[8*d+7:8*d], and entry 0 is the leftmost digit.
- R4: With hostFlN high and hostAddr[3]=0, the full data byte is stored in the control word. Its fields are bits 2..0 brightness, bit 3 flash enable, bit 4 blink enable, bit 5 unused, bit 6 lamp test and bit 7 clear.
- R5: With hostFlN low, hostData[0] is stored in flash bit hostAddr[2:0] (flashBits[d]). hostAddr[3] and hostData[7:1] are ignored, and neither the character memory nor the control word changes.
- R6: A write takes effect only after the strobe returns high. While hostWrN is held low, no store changes.
- R7: A control word with bit 7 set stores that word unchanged, fills every character entry with 8'h20 and zeros every flash bit.
- R8: After a control word with bit 7 set, clearBusy stays high for exactly CLEAR_CYCLES clock cycles and then falls by itself.
- R9: While clearBusy is high, character and flash writes have no effect.
- R10: A control word with bit 7 clear that is written while clearBusy is high is stored, and clearBusy drops on the next cycle. After that, character writes take effect again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostCeN | input | 1 | Active-low chip enable |
| hostWrN | input | 1 | Active-low write strobe; acted on at its rising edge |
| hostFlN | input | 1 | Active-low flash-memory select |
| hostAddr | input | 4 | Bit 3 picks character (1) or control (0); bits 2..0 pick the digit |
| hostData | input | 8 | Write data byte |
| charFlat | output | 64 | All eight character entries, entry d at bits 8*d+7..8*d |
| flashBits | output | 8 | Flash bit per digit |
| ctrlWord | output | 8 | Stored control word |
| clearBusy | output | 1 | High while a clear is in progress |

## Verification
The bench measures the length of the busy period cycle by cycle. A timer that is off by one, or that reloads on the wrong edge, shows up as a wrong count. It fires character and flash writes into the middle of a clear; a design that fails to block them would show the new data instead of spaces. It also ends a clear early with a control word whose bit 7 is low, which catches a design that ignores the early exit or drops that word. It holds the strobe low for many cycles to catch writes made on the falling edge, and it sends flash writes with junk in the upper data bits and the mode bit to catch leakage into the other stores.

// File: rtl/dispHostPkg.sv
package dispHostPkg;
  localparam int DISP_DIGITS = 8;
  localparam int DISP_IDX_W  = $clog2(DISP_DIGITS);
  localparam int DISP_ADDR_W = DISP_IDX_W + 1;
  localparam int DISP_DATA_W = 8;
  localparam logic [DISP_DATA_W-1:0] SPACE_CODE = 8'h20;
  localparam int CLEAR_BIT = DISP_DATA_W - 1;

  // host bus sample, one per synchroniser stage
  typedef struct packed {
    logic                   wrN;
    logic                   ceN;
    logic                   flN;
    logic [DISP_ADDR_W-1:0] addr;
    logic [DISP_DATA_W-1:0] data;
  } hostBus_t;

  // strobes from control to datapath
  typedef struct packed {
    logic                   charWe;
    logic                   flashWe;
    logic                   ctrlWe;
    logic                   clearAll;
    logic [DISP_IDX_W-1:0]  idx;
    logic [DISP_DATA_W-1:0] data;
  } regCmd_t;
endpackage

// File: rtl/dispHostSync.sv
module dispHostSync
  import dispHostPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  hostBus_t busIn,
  output logic     wrEvent,
  output hostBus_t busOut
);
  localparam hostBus_t IDLE_BUS = '{wrN: 1'b1, ceN: 1'b1, flN: 1'b1, addr: '0, data: '0};

  hostBus_t stg [SYNC_STAGES+1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s <= SYNC_STAGES; s++) stg[s] <= IDLE_BUS;
    end else begin
      stg[0] <= busIn;
      for (int s = 1; s <= SYNC_STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  // rising strobe edge; the oldest stage holds the last low sample
  assign wrEvent = stg[SYNC_STAGES-1].wrN && !stg[SYNC_STAGES].wrN
                   && !stg[SYNC_STAGES].ceN;
  assign busOut  = stg[SYNC_STAGES];

  // R6: one strobe release gives exactly one event
  p_single_event_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrEvent |=> !wrEvent);
endmodule

// File: rtl/dispHostCtrl.sv
module dispHostCtrl
  import dispHostPkg::*;
#(
  parameter int CLEAR_CYCLES = 750000
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     wrEvent,
  input  hostBus_t bus,
  output regCmd_t  cmd,
  output logic     clearBusy
);
  localparam int CNT_W = $clog2(CLEAR_CYCLES + 1);

  logic [CNT_W-1:0] clrCnt;
  logic isFlash, isChar, isCtrl;

  always_comb begin
    isFlash = !bus.flN;
    isChar  = bus.flN && bus.addr[DISP_ADDR_W-1];
    isCtrl  = bus.flN && !bus.addr[DISP_ADDR_W-1];
    cmd          = '0;
    cmd.idx      = bus.addr[DISP_IDX_W-1:0];
    cmd.data     = bus.data;
    cmd.charWe   = wrEvent && isChar  && !clearBusy;
    cmd.flashWe  = wrEvent && isFlash && !clearBusy;
    cmd.ctrlWe   = wrEvent && isCtrl;
    cmd.clearAll = wrEvent && isCtrl && bus.data[CLEAR_BIT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clearBusy <= 1'b0;
      clrCnt    <= '0;
    end else if (cmd.clearAll) begin
      clearBusy <= 1'b1;
      clrCnt    <= CNT_W'(CLEAR_CYCLES - 1);
    end else if (cmd.ctrlWe) begin
      clearBusy <= 1'b0;
      clrCnt    <= '0;
    end else if (clearBusy) begin
      if (clrCnt == '0) clearBusy <= 1'b0;
      else              clrCnt    <= clrCnt - 1'b1;
    end
  end

  // R9: no character or flash strobe while a clear runs
  p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rstN)
    clearBusy |-> !cmd.charWe && !cmd.flashWe);
  // R8: a clear request makes the block busy
  p_clear_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clearAll |=> clearBusy);
  // R8: timer stays inside its window
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    clrCnt < CNT_W'(CLEAR_CYCLES));
  // R10: a control word without clear ends the busy period
  p_early_end_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.ctrlWe && !cmd.data[CLEAR_BIT]) |=> !clearBusy);
  // R3/R4/R5: at most one store strobe per cycle
  p_one_store_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.charWe, cmd.flashWe, cmd.ctrlWe}));
endmodule

// File: rtl/dispHostStore.sv
module dispHostStore
  import dispHostPkg::*;
(
  input  logic                               clk,
  input  logic                               rstN,
  input  regCmd_t                            cmd,
  output logic [DISP_DIGITS*DISP_DATA_W-1:0] charFlat,
  output logic [DISP_DIGITS-1:0]             flashBits,
  output logic [DISP_DATA_W-1:0]             ctrlWord
);
  logic [DISP_DATA_W-1:0] charMem [DISP_DIGITS];
  logic [DISP_DIGITS-1:0] flashMem;
  logic [DISP_DATA_W-1:0] ctrlReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int d = 0; d < DISP_DIGITS; d++) charMem[d] <= SPACE_CODE;
      flashMem <= '0;
      ctrlReg  <= '0;
    end else begin
      if (cmd.clearAll) begin
        for (int d = 0; d < DISP_DIGITS; d++) charMem[d] <= SPACE_CODE;
        flashMem <= '0;
      end else begin
        if (cmd.charWe)  charMem[cmd.idx]  <= cmd.data;
        if (cmd.flashWe) flashMem[cmd.idx] <= cmd.data[0];
      end
      if (cmd.ctrlWe) ctrlReg <= cmd.data;
    end
  end

  genvar g;
  generate
    for (g = 0; g < DISP_DIGITS; g++) begin : g_flat
      assign charFlat[g*DISP_DATA_W +: DISP_DATA_W] = charMem[g];
    end
  endgenerate
  assign flashBits = flashMem;
  assign ctrlWord  = ctrlReg;

  // R7: clear leaves spaces and zero flash bits
  p_clear_fill_r7: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clearAll |=> (charFlat == {DISP_DIGITS{SPACE_CODE}}) && (flashBits == '0));
  // R4: control word only changes on a control write
  p_ctrl_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.ctrlWe |=> $stable(ctrlWord));
  // R5: flash write leaves character memory alone
  p_char_intact_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmd.flashWe |=> $stable(charFlat));
endmodule

// File: rtl/dispHostRegs.sv
module dispHostRegs
  import dispHostPkg::*;
#(
  parameter int CLEAR_CYCLES = 750000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostCeN,
  input  logic        hostWrN,
  input  logic        hostFlN,
  input  logic [3:0]  hostAddr,
  input  logic [7:0]  hostData,
  output logic [63:0] charFlat,
  output logic [7:0]  flashBits,
  output logic [7:0]  ctrlWord,
  output logic        clearBusy
);
  hostBus_t busIn, busSync;
  logic     wrEvent;
  regCmd_t  cmd;

  assign busIn = '{wrN: hostWrN, ceN: hostCeN, flN: hostFlN,
                   addr: hostAddr, data: hostData};

  dispHostSync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .busIn(busIn), .wrEvent(wrEvent), .busOut(busSync));

  dispHostCtrl #(.CLEAR_CYCLES(CLEAR_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEvent(wrEvent), .bus(busSync),
    .cmd(cmd), .clearBusy(clearBusy));

  dispHostStore store_i (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .charFlat(charFlat), .flashBits(flashBits), .ctrlWord(ctrlWord));
endmodule

// File: tb/dispHostRegs_tb.sv
module dispHostRegs_tb_top;
  localparam int CLR = 200;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostCeN = 1'b1, hostWrN = 1'b1, hostFlN = 1'b1;
  logic [3:0] hostAddr = '0;
  logic [7:0] hostData = '0;
  logic [63:0] charFlat;
  logic [7:0] flashBits, ctrlWord;
  logic clearBusy;

  int nChecks = 0, nFails = 0;
  logic [7:0] expChar [8];
  logic [7:0] expFlash, expCtrl;

  always #2 clk = ~clk;

  dispHostRegs #(.CLEAR_CYCLES(CLR)) dut_i (
    .clk(clk), .rstN(rstN), .hostCeN(hostCeN), .hostWrN(hostWrN), .hostFlN(hostFlN),
    .hostAddr(hostAddr), .hostData(hostData), .charFlat(charFlat),
    .flashBits(flashBits), .ctrlWord(ctrlWord), .clearBusy(clearBusy));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chkStores(input string req);
    logic [63:0] e;
    for (int d = 0; d < 8; d++) e[d*8 +: 8] = expChar[d];
    chk({req, " chars"}, charFlat, e);
    chk({req, " flash"}, {56'd0, flashBits}, {56'd0, expFlash});
    chk({req, " ctrl"}, {56'd0, ctrlWord}, {56'd0, expCtrl});
  endtask

  // strobe low three cycles then release; returns at the release
  task automatic hostPulse(input logic ce, input logic fl, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    hostCeN = ce; hostFlN = fl; hostAddr = a; hostData = d; hostWrN = 1'b0;
    repeat (3) @(negedge clk);
    hostWrN = 1'b1;
  endtask

  task automatic hostWrite(input logic ce, input logic fl, input logic [3:0] a, input logic [7:0] d);
    hostPulse(ce, fl, a, d);
    repeat (5) @(negedge clk);
    hostCeN = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    int busyCnt;
    logic [7:0] v;
    for (int d = 0; d < 8; d++) expChar[d] = 8'h20;
    expFlash = '0; expCtrl = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    chkStores("R1");
    chk("R1 busy", {63'd0, clearBusy}, 64'd0);

    // R3 character writes, every digit, several patterns incl page bit
    for (int p = 0; p < 3; p++) begin
      for (int d = 0; d < 8; d++) begin
        v = 8'((d * 37 + p * 91 + 5) ^ (p == 2 ? 8'h80 : 8'h00));
        hostWrite(1'b0, 1'b1, {1'b1, 3'(d)}, v);
        expChar[d] = v;
      end
      chkStores("R3");
    end

    // R4 control word sweep, all values with bit 7 clear
    for (int c = 0; c < 128; c++) begin
      hostWrite(1'b0, 1'b1, 4'h0 | 4'(c % 8), 8'(c));
      expCtrl = 8'(c);
      chk("R4 ctrl", {56'd0, ctrlWord}, {56'd0, expCtrl});
    end
    chkStores("R4");

    // R5 flash writes with junk upper bits and both mode-bit values
    for (int d = 0; d < 8; d++) begin
      v = 8'hA6 | 8'(d % 2);
      hostWrite(1'b0, 1'b0, {1'(d / 4), 3'(d)}, v);
      expFlash[d] = v[0];
      chkStores("R5");
    end
    hostWrite(1'b0, 1'b0, 4'hB, 8'hFE);
    expFlash[3] = 1'b0;
    chkStores("R5 clear bit");

    // R2 chip enable high: nothing stored
    hostWrite(1'b1, 1'b1, 4'h9, 8'h55);
    hostWrite(1'b1, 1'b1, 4'h0, 8'h9F);
    hostWrite(1'b1, 1'b0, 4'h0, 8'h01);
    chkStores("R2");

    // R6 strobe held low: no change until release
    @(negedge clk);
    hostCeN = 1'b0; hostFlN = 1'b1; hostAddr = 4'hC; hostData = 8'h3C; hostWrN = 1'b0;
    repeat (20) @(negedge clk);
    chkStores("R6 held low");
    hostWrN = 1'b1;
    repeat (5) @(negedge clk);
    hostCeN = 1'b1;
    expChar[4] = 8'h3C;
    chkStores("R6 released");

    // R7/R8 clear with duration count
    hostPulse(1'b0, 1'b1, 4'h0, 8'h85);
    busyCnt = 0;
    for (int t = 0; t < CLR + 20; t++) begin
      @(negedge clk);
      if (clearBusy) busyCnt++;
    end
    hostCeN = 1'b1;
    chk("R8 busy cycles", 64'(busyCnt), 64'(CLR));
    chk("R8 busy low", {63'd0, clearBusy}, 64'd0);
    for (int d = 0; d < 8; d++) expChar[d] = 8'h20;
    expFlash = '0; expCtrl = 8'h85;
    chkStores("R7");

    // refill, then clear again and try writes during it
    hostWrite(1'b0, 1'b1, 4'h8, 8'h41);
    hostWrite(1'b0, 1'b0, 4'h1, 8'h01);
    expChar[0] = 8'h41; expFlash[1] = 1'b1;
    chkStores("R3 after clear");
    hostWrite(1'b0, 1'b1, 4'h0, 8'hC0);
    for (int d = 0; d < 8; d++) expChar[d] = 8'h20;
    expFlash = '0; expCtrl = 8'hC0;
    chk("R8 busy set", {63'd0, clearBusy}, 64'd1);
    hostWrite(1'b0, 1'b1, 4'hA, 8'h77);
    hostWrite(1'b0, 1'b0, 4'h6, 8'h01);
    chk("R9 still busy", {63'd0, clearBusy}, 64'd1);
    chkStores("R9");

    // R10 early end
    hostWrite(1'b0, 1'b1, 4'h0, 8'h13);
    expCtrl = 8'h13;
    chk("R10 busy", {63'd0, clearBusy}, 64'd0);
    chkStores("R10");
    hostWrite(1'b0, 1'b1, 4'hF, 8'h5A);
    expChar[7] = 8'h5A;
    chkStores("R10 write after");

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule